// File: doc/BRIEF.md
# Calibrated Thermal Code Converter

This block turns a stream of raw sensor codes into a junction temperature in millidegrees Celsius. It takes samples over a valid/ready handshake, keeps only the low twelve bits of each, and averages groups of eight. The average then goes through an integer curvature correction. A two-point linear calibration maps the corrected value onto the temperature scale, and the result is rounded up to a 500 m°C step. The output is a signed 32-bit value, announced by a one-cycle done pulse.

The two calibration points come from two 32-bit trim words. Each trim word carries a valid flag in bit 31. When the flag is set, the point is the twelve-bit field in bits 11:0. When the flag is clear, a fixed default is used: 3148 for the hot point and 503 for the cold point. The trim words are sampled once per conversion, at the moment the eighth sample has been absorbed.

All divisions share one iterative divider, so a conversion takes roughly a hundred cycles. The sample input refuses new codes while a conversion is computing. Collection of the next group resumes in the cycle the done pulse is shown.

Top module: `thermo_cal_conv`

## Requirements
- R1: Only bits 11:0 of each accepted sample contribute; bits above 11 have no effect on the result.
- R2: Each result uses exactly eight consecutive accepted samples, averaged as floor(sum/8), and the sample accumulator clears after the eighth.
- R3: The corrected value is floor(avg×1000000 / (1000000 + avg×13)), valid over the full code range 0..4095.
- R4: A trim word with bit 31 set supplies its bits 11:0 as the calibration point; with bit 31 clear the hot point defaults to 3148 and the cold point to 503.
- R5: The slope is the integer quotient floor(165000 / (hot − cold)) formed before the multiply; when hot is not greater than cold the slope is zero.
- R6: The output is ceil((corrected − cold) × slope − 40000) to a multiple of 500, rounding toward positive infinity for negative values too.
- R7: done_o is high for exactly one cycle per completed group, and temp_mc_o changes only in a cycle where done_o is high and then holds.
- R8: smp_ready_o is low from the cycle after the eighth sample is accepted until done_o rises, and is high in the done_o cycle, so a sample offered in that cycle counts toward the next group.
- R9: After reset smp_ready_o is high, done_o is low and temp_mc_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid_i | input | 1 | Sample offered |
| smp_code_i | input | IN_W (16) | Raw sample code; only bits 11:0 are used |
| smp_ready_o | output | 1 | Sample accepted on a clock edge where valid and ready are both high |
| trim_hi_i | input | 32 | Hot-point trim word: bit 31 valid flag, bits 11:0 value |
| trim_lo_i | input | 32 | Cold-point trim word: bit 31 valid flag, bits 11:0 value |
| temp_mc_o | output | 32 | Signed temperature in m°C, held between results |
| done_o | output | 1 | One-cycle pulse when temp_mc_o is updated |

## Verification
The done pulse of one group and the acceptance of the first sample of the next group fall in the same cycle. The bench provokes this by holding smp_valid_i high without a gap across two back-to-back groups, so the next code is waiting when ready returns. The result of each group is compared with a value computed independently in the bench. A monitor checks every cycle that ready stays low while a conversion is in flight and is high exactly at the done pulse. A lost, extra or double-counted sample shows up as a wrong second result.

// File: rtl/thermo_conv_pkg.sv
// Package: shared constants and the sequencer state type of the thermal
// code converter. Assumes codes are 12 bits and the datapath is 32 bits.
package thermo_conv_pkg;
    localparam int CODE_W       = 12;
    localparam int DATA_W       = 32;
    localparam int TRIM_W       = 32;
    localparam int TRIM_VLD_BIT = 31;
    localparam int SCALE        = 1000000;
    localparam int CURV_K       = 13;
    localparam int SPAN_MC      = 165000;
    localparam int OFFSET_MC    = 40000;
    localparam int STEP_MC      = 500;
    localparam int CAL_HI_DEF   = 3148;
    localparam int CAL_LO_DEF   = 503;

    typedef enum logic [2:0] {
        S_COLLECT,
        S_CORR_GO,
        S_CORR_WT,
        S_SLP_GO,
        S_SLP_WT,
        S_LIN,
        S_RND_GO,
        S_RND_WT
    } conv_state_e;
endpackage

// File: rtl/thermo_sample_avg.sv
// Sample accumulator: masks each accepted code to CODE_W bits and sums
// SAMPLES of them, then emits the truncated average with a one-cycle valid.
// Assumes SAMPLES is a power of two and IN_W > CODE_W.
module thermo_sample_avg #(
    parameter int IN_W    = 16,
    parameter int CODE_W  = 12,
    parameter int SAMPLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [IN_W-1:0]   code_i,
    output logic              avg_vld_o,
    output logic [CODE_W-1:0] avg_o
);
    localparam int CNT_W = $clog2(SAMPLES);
    localparam int SUM_W = CODE_W + CNT_W;

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_next;
    logic             unused_hi_bits;

    assign unused_hi_bits = ^code_i[IN_W-1:CODE_W];
    assign sum_next       = sum_q + SUM_W'(code_i[CODE_W-1:0]);

    // Accumulate masked codes and release the average after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sum_q     <= '0;
            avg_vld_o <= 1'b0;
            avg_o     <= '0;
        end else begin
            avg_vld_o <= 1'b0;
            if (acc_i) begin
                if (cnt_q == CNT_W'(SAMPLES - 1)) begin
                    avg_o     <= sum_next[SUM_W-1:CNT_W];
                    avg_vld_o <= 1'b1;
                    sum_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    sum_q <= sum_next;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8: no sample is taken while a finished average is being handed over.
    assert_no_accept_on_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_o |-> !acc_i);

    // R2: each completed group yields a single average strobe.
    assert_avg_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_o |=> !avg_vld_o);
endmodule

// File: rtl/thermo_seq_div.sv
// Iterative restoring divider: unsigned W-bit dividend by W-bit divisor,
// one quotient bit per cycle, done pulses W cycles after start.
// Assumes start is only raised while idle. A zero divisor yields all-ones.
module thermo_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     dvs_q;
    logic [W:0]       shifted;
    logic [W+1:0]     trial;
    logic             borrow;

    assign shifted = {rem_o, quo_o[W-1]};
    assign trial   = {1'b0, shifted} - {2'b00, dvs_q};
    assign borrow  = trial[W+1];

    // Load operands on start, then retire one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
            dvs_q  <= '0;
            quo_o  <= '0;
            rem_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                quo_o  <= dvd_i;
                rem_o  <= '0;
                dvs_q  <= dvs_i;
                cnt_q  <= CNT_W'(W);
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (!borrow) begin
                    rem_o <= trial[W-1:0];
                    quo_o <= {quo_o[W-2:0], 1'b1};
                end else begin
                    rem_o <= shifted[W-1:0];
                    quo_o <= {quo_o[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // R3: the sequencer never restarts the divider mid-operation.
    assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R3: a finished division leaves a remainder below the divisor.
    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dvs_q != '0) |-> (rem_o < dvs_q));
endmodule

// File: rtl/thermo_trim_decode.sv
// Trim decoder: picks the CODE_W-bit field of a trim word when its valid
// flag is set, otherwise a fixed default point. Purely combinational.
module thermo_trim_decode #(
    parameter int DEF_VAL = 0
) (
    input  logic [thermo_conv_pkg::TRIM_W-1:0] trim_i,
    output logic [thermo_conv_pkg::CODE_W-1:0] cal_o
);
    import thermo_conv_pkg::*;

    logic unused_mid_bits;
    assign unused_mid_bits = ^trim_i[TRIM_VLD_BIT-1:CODE_W];

    // Select trimmed value or default by the valid flag.
    always_comb begin
        if (trim_i[TRIM_VLD_BIT]) cal_o = trim_i[CODE_W-1:0];
        else                      cal_o = CODE_W'(DEF_VAL);
    end
endmodule

// File: rtl/thermo_cal_conv.sv
// Top: collects SAMPLES codes, then sequences one shared divider through
// curvature correction, slope and rounding, and publishes the signed
// temperature in m°C with a one-cycle done pulse. Assumes trim words are
// stable at the cycle the group's average is formed.
module thermo_cal_conv #(
    parameter int IN_W    = 16,
    parameter int SAMPLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid_i,
    input  logic [IN_W-1:0]     smp_code_i,
    output logic                smp_ready_o,
    input  logic [31:0]         trim_hi_i,
    input  logic [31:0]         trim_lo_i,
    output logic signed [31:0]  temp_mc_o,
    output logic                done_o
);
    import thermo_conv_pkg::*;

    localparam logic [DATA_W-1:0] K_SCALE  = DATA_W'(SCALE);
    localparam logic [DATA_W-1:0] K_CURV   = DATA_W'(CURV_K);
    localparam logic [DATA_W-1:0] K_SPAN   = DATA_W'(SPAN_MC);
    localparam logic [DATA_W-1:0] K_OFFSET = DATA_W'(OFFSET_MC);
    localparam logic [DATA_W-1:0] K_STEP   = DATA_W'(STEP_MC);

    conv_state_e               state_q;
    logic                      avg_vld;
    logic [CODE_W-1:0]         avg;
    logic [CODE_W-1:0]         cal_hi_d, cal_lo_d;
    logic [CODE_W-1:0]         avg_q, cal_hi_q, cal_lo_q;
    logic [DATA_W-1:0]         corr_q, slope_q;
    logic signed [DATA_W-1:0]  lin_q;
    logic                      acc;
    logic                      div_start, div_busy, div_done;
    logic [DATA_W-1:0]         div_dvd, div_dvs, div_quo, div_rem;
    logic [DATA_W-1:0]         avg_ext, span, lin_abs;
    logic signed [DATA_W-1:0]  lin_d;
    logic [DATA_W-1:0]         up_mag, res_pos, res_neg;

    assign smp_ready_o = (state_q == S_COLLECT) && !avg_vld;
    assign acc         = smp_valid_i && smp_ready_o;

    thermo_sample_avg #(.IN_W(IN_W), .CODE_W(CODE_W), .SAMPLES(SAMPLES)) avg_i (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .code_i(smp_code_i),
        .avg_vld_o(avg_vld), .avg_o(avg)
    );

    thermo_trim_decode #(.DEF_VAL(CAL_HI_DEF)) trim_hi_dec_i (.trim_i(trim_hi_i), .cal_o(cal_hi_d));
    thermo_trim_decode #(.DEF_VAL(CAL_LO_DEF)) trim_lo_dec_i (.trim_i(trim_lo_i), .cal_o(cal_lo_d));

    thermo_seq_div #(.W(DATA_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start_i(div_start), .dvd_i(div_dvd), .dvs_i(div_dvs),
        .busy_o(div_busy), .done_o(div_done), .quo_o(div_quo), .rem_o(div_rem)
    );

    assign avg_ext = DATA_W'(avg_q);
    assign span    = DATA_W'(cal_hi_q) - DATA_W'(cal_lo_q);
    assign lin_abs = lin_q[DATA_W-1] ? (~lin_q + 1'b1) : lin_q;
    assign lin_d   = $signed(corr_q - DATA_W'(cal_lo_q)) * $signed(slope_q);
    assign up_mag  = div_quo + ((div_rem != '0) ? DATA_W'(1) : DATA_W'(0));
    assign res_pos = up_mag * K_STEP - K_OFFSET;
    assign res_neg = '0 - (div_quo * K_STEP) - K_OFFSET;

    // Route the operands of the current division step to the shared divider.
    always_comb begin
        div_start = 1'b0;
        div_dvd   = '0;
        div_dvs   = DATA_W'(1);
        case (state_q)
            S_CORR_GO: begin
                div_start = 1'b1;
                div_dvd   = avg_ext * K_SCALE;
                div_dvs   = K_SCALE + avg_ext * K_CURV;
            end
            S_SLP_GO: begin
                div_start = 1'b1;
                div_dvd   = K_SPAN;
                div_dvs   = span;
            end
            S_RND_GO: begin
                div_start = 1'b1;
                div_dvd   = lin_abs;
                div_dvs   = K_STEP;
            end
            default: ;
        endcase
    end

    // Sequence collection, the three divisions, the multiply and the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_COLLECT;
            avg_q     <= '0;
            cal_hi_q  <= '0;
            cal_lo_q  <= '0;
            corr_q    <= '0;
            slope_q   <= '0;
            lin_q     <= '0;
            temp_mc_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                S_COLLECT: if (avg_vld) begin
                    avg_q    <= avg;
                    cal_hi_q <= cal_hi_d;
                    cal_lo_q <= cal_lo_d;
                    state_q  <= S_CORR_GO;
                end
                S_CORR_GO: state_q <= S_CORR_WT;
                S_CORR_WT: if (div_done) begin
                    corr_q  <= div_quo;
                    state_q <= S_SLP_GO;
                end
                S_SLP_GO: state_q <= S_SLP_WT;
                S_SLP_WT: if (div_done) begin
                    slope_q <= (cal_hi_q > cal_lo_q) ? div_quo : '0;
                    state_q <= S_LIN;
                end
                S_LIN: begin
                    lin_q   <= lin_d;
                    state_q <= S_RND_GO;
                end
                S_RND_GO: state_q <= S_RND_WT;
                S_RND_WT: if (div_done) begin
                    temp_mc_o <= lin_q[DATA_W-1] ? $signed(res_neg) : $signed(res_pos);
                    done_o    <= 1'b1;
                    state_q   <= S_COLLECT;
                end
                default: state_q <= S_COLLECT;
            endcase
        end
    end

    // R7: the done strobe never lasts two cycles.
    assert_done_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the published temperature moves only together with done.
    assert_temp_changes_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_mc_o != $past(temp_mc_o)) |-> done_o);

    // R6: every published value sits on the 500 m°C grid.
    assert_on_step_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((temp_mc_o % 500) == 0));

    // R8: collection is open again in the cycle the result is shown.
    assert_ready_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> smp_ready_o);

    // R8: the divider is never running while samples are being accepted.
    assert_no_accept_while_dividing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !acc);
endmodule

// File: tb/thermo_cal_conv_tb_top.sv
// Directed bench: one task per scenario; a negedge monitor records results
// and checks the ready/done handshake every cycle.
module thermo_cal_conv_tb_top;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               smp_valid_i;
    logic [15:0]        smp_code_i;
    logic               smp_ready_o;
    logic [31:0]        trim_hi_i, trim_lo_i;
    logic signed [31:0] temp_mc_o;
    logic               done_o;

    int n_chk  = 0;
    int n_fail = 0;
    int res [64];
    int res_n  = 0;
    int rd_idx = 0;
    int n_acc  = 0;
    bit in_flight = 1'b0;
    bit prev_done = 1'b0;
    logic [15:0] batch [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_cal_conv dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_code_i(smp_code_i),
        .smp_ready_o(smp_ready_o), .trim_hi_i(trim_hi_i), .trim_lo_i(trim_lo_i),
        .temp_mc_o(temp_mc_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Handshake monitor: done width (R7), ready closed in flight and open at done (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R7 done width", 1, 0);
                check(smp_ready_o, "R8 ready at done", int'(smp_ready_o), 1);
                res[res_n % 64] = temp_mc_o;
                res_n++;
                in_flight = 1'b0;
            end else if (in_flight) begin
                check(!smp_ready_o, "R8 ready while busy", int'(smp_ready_o), 0);
            end
            if (smp_valid_i && smp_ready_o) begin
                n_acc++;
                if (n_acc == 8) begin
                    n_acc = 0;
                    in_flight = 1'b1;
                end
            end
            prev_done = done_o;
        end
    end

    function automatic int model(input logic [15:0] c [8], input logic [31:0] th, input logic [31:0] tl);
        longint s = 0;
        longint avg, corr, chi, clo, span, slope;
        int lin, v, q;
        for (int i = 0; i < 8; i++) s += longint'(c[i] & 16'h0FFF);
        avg   = s / 8;
        corr  = (avg * 1000000) / (1000000 + avg * 13);
        chi   = th[31] ? longint'(th[11:0]) : 3148;
        clo   = tl[31] ? longint'(tl[11:0]) : 503;
        span  = chi - clo;
        slope = (span > 0) ? (165000 / span) : 0;
        lin   = int'((corr - clo) * slope);
        v     = lin - 40000;
        q     = v / 500;
        if ((v % 500) > 0) q++;
        return q * 500;
    endfunction

    // Offer one code; returns one step after the edge that accepted it.
    task automatic send(input logic [15:0] c);
        smp_valid_i = 1'b1;
        smp_code_i  = c;
        @(negedge clk);
        while (!smp_ready_o) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic feed_batch();
        for (int i = 0; i < 8; i++) send(batch[i]);
    endtask

    task automatic expect_next(input int exp, input string req);
        int waited = 0;
        while (res_n <= rd_idx && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        if (res_n <= rd_idx) check(1'b0, {req, " no result"}, 0, exp);
        else check(res[rd_idx % 64] == exp, req, res[rd_idx % 64], exp);
        rd_idx++;
    endtask

    task automatic fill(input logic [15:0] v);
        for (int i = 0; i < 8; i++) batch[i] = v;
    endtask

    task automatic run_one(input string req);
        int e;
        e = model(batch, trim_hi_i, trim_lo_i);
        feed_batch();
        smp_valid_i = 1'b0;
        expect_next(e, req);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();   // R9
        check(smp_ready_o == 1'b1, "R9 ready after reset", int'(smp_ready_o), 1);
        check(done_o == 1'b0, "R9 done after reset", int'(done_o), 0);
        check(temp_mc_o == 0, "R9 temp after reset", temp_mc_o, 0);
    endtask

    task automatic t_default_mid();   // R3 R4 R6: 2000 with defaults -> 50000
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        fill(16'd2000);
        check(model(batch, trim_hi_i, trim_lo_i) == 50000, "R3 model sanity", model(batch, trim_hi_i, trim_lo_i), 50000);
        run_one("R4 default points");
        check(temp_mc_o == 50000, "R7 temp held", temp_mc_o, 50000);
    endtask

    task automatic t_mask();   // R1: upper bits set, 12-bit field is 2000
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        fill(16'hF7D0);
        batch[3] = 16'h17D0;
        run_one("R1 upper bits ignored");
    endtask

    task automatic t_average();   // R2: sum not divisible by 8 truncates
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        for (int i = 0; i < 8; i++) batch[i] = 16'(1500 + 37 * i + (i % 3));
        run_one("R2 truncated average");
        for (int i = 0; i < 8; i++) batch[i] = (i < 7) ? 16'd4000 : 16'd7;
        run_one("R2 skewed group");
    endtask

    task automatic t_trims();   // R4: flag set uses field, flag clear uses default
        trim_hi_i = 32'h8000_0C40; trim_lo_i = 32'h8000_01F0;
        fill(16'd2500);
        run_one("R4 trimmed points");
        trim_hi_i = 32'h0000_0AAA; trim_lo_i = 32'h8000_0100;
        run_one("R4 hot default, cold trimmed");
        trim_hi_i = 32'h7FFF_FFFF; trim_lo_i = 32'h7FFF_FFFF;
        run_one("R4 flags clear, other bits set");
    endtask

    task automatic t_negative();   // R6: -25048 rounds up to -25000, result -65000
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        fill(16'd100);
        check(model(batch, trim_hi_i, trim_lo_i) == -65000, "R6 model sanity", model(batch, trim_hi_i, trim_lo_i), -65000);
        run_one("R6 negative round toward +inf");
        fill(16'd0);
        run_one("R6 zero code");
    endtask

    task automatic t_flat_span();   // R5: hot == cold or hot < cold -> -40000
        trim_hi_i = 32'h8000_0400; trim_lo_i = 32'h8000_0400;
        fill(16'd3000);
        run_one("R5 equal points");
        check(temp_mc_o == -40000, "R5 equal points value", temp_mc_o, -40000);
        trim_hi_i = 32'h8000_0100; trim_lo_i = 32'h8000_0900;
        run_one("R5 inverted points");
    endtask

    task automatic t_full_scale();   // R3: top code 4095
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        fill(16'h0FFF);
        run_one("R3 full-scale code");
    endtask

    task automatic t_back_to_back();   // R7 R8: next group's first code accepted at done
        int ea, eb;
        trim_hi_i = 32'h0; trim_lo_i = 32'h0;
        fill(16'd1200);
        ea = model(batch, trim_hi_i, trim_lo_i);
        feed_batch();
        for (int i = 0; i < 8; i++) batch[i] = 16'(3300 - 91 * i);
        eb = model(batch, trim_hi_i, trim_lo_i);
        feed_batch();
        smp_valid_i = 1'b0;
        expect_next(ea, "R8 first of back-to-back");
        expect_next(eb, "R8 second group intact");
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; smp_valid_i = 1'b0; smp_code_i = '0;
        trim_hi_i = '0; trim_lo_i = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(posedge clk);
        #1;
        t_default_mid();
        t_mask();
        t_average();
        t_trims();
        t_negative();
        t_flat_span();
        t_full_scale();
        t_back_to_back();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", res_n, rd_idx);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule